// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end that decides which 6-bit attenuation code a binary-weighted step attenuator receives. The code has six bits. Bit 5 is worth 16 dB, bit 4 is 8 dB, bit 3 is 4 dB, bit 2 is 2 dB, bit 1 is 1 dB and bit 0 is 0.5 dB. Code 0 is the minimum-loss reference state and code 63 is 31.5 dB. A mode input chooses the source of the code. It can come from a six-wire parallel bus or from a three-wire serial port (data, serial clock, latch enable).

The serial port fills a 6-bit shift register, most significant bit first. A register that acts as a level-sensitive latch sits between the selected source and the output. While latch enable is high, the output follows the source. While latch enable is low, the output holds. Driving the parallel bus with latch enable tied high gives direct control. Keeping latch enable low and pulsing it gives latched control.

A synchronous power-on input loads a known code. In serial mode, and in parallel mode with latch enable high, that code is taken from the parallel pins. In parallel mode with latch enable low, two preset-select pins choose one of four fixed codes. All inputs are sampled on the system clock. The serial clock is edge-detected against that system clock.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `por` is high with `mode_ser`=1, the next clock loads `atten_word` with `par_word`.
- R2: While `por` is high with `mode_ser`=0 and `latch_en`=0, the next clock loads `atten_word` from `pup_sel`: 0 gives 6'b000000, 1 gives 6'b010000 (8 dB), 2 gives 6'b100000 (16 dB), 3 gives 6'b111110 (31 dB).
- R3: While `por` is high with `mode_ser`=0 and `latch_en`=1, `atten_word` is loaded from `par_word` and `pup_sel` has no effect.
- R4: Each rising edge of `ser_clk`, seen as a low-to-high change between two consecutive clock samples, shifts `ser_dat` into the shift register at bit 0, whatever the level of `latch_en`. After six shifts the first bit sits in bit 5. `por` clears the shift register.
- R5: With `mode_ser`=1 and `latch_en`=1, `atten_word` takes the value the shift register had at the previous clock. Partial shift values therefore pass through.
- R6: While `latch_en`=0 and `por`=0, `atten_word` does not change, whatever happens on `ser_clk`, `ser_dat`, `par_word` or `pup_sel`.
- R7: With `mode_ser`=0 and `latch_en`=1, `atten_word` follows `par_word` one clock later.
- R8: In parallel mode, a one-cycle high pulse on `latch_en` captures `par_word` into `atten_word`, and the code then holds after `latch_en` falls.
- R9: Changing `mode_ser` switches the latch source on the next clock and never reloads a preset code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on load, active high |
| mode_ser | input | 1 | 1 selects the serial source, 0 selects the parallel source |
| latch_en | input | 1 | Latch enable: high is transparent, low holds |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| ser_dat | input | 1 | Serial data, most significant bit first |
| par_word | input | 6 | Parallel attenuation code |
| pup_sel | input | 2 | Preset select used at power-on in latched parallel mode |
| atten_word | output | 6 | Registered attenuation code driving the attenuator |

## Verification
The bench shifts a full word with latch enable low and checks that the output never moves. A design that tied the shift register straight to the output would show every partial value. It then repeats the shift with latch enable high and expects each partial value one clock after its shift; a latch that only captured on the falling edge would miss all of them. Each of the four preset codes and the direct-parallel power-on case are loaded, so a swapped preset value, or presets applied while latch enable is high, would show up as a wrong code. Mode switches under both latch levels catch a design that re-runs the preset logic or delays the source change. A model is compared on every clock to catch bits entering in the wrong order or shifts on the wrong serial-clock edge.

// File: rtl/atten_pkg.sv
package atten_pkg;

   typedef enum logic {
      SRC_PARALLEL = 1'b0,
      SRC_SERIAL   = 1'b1
   } atten_src_e;

   // Code value of a level in half-dB steps: the code is the loss times two.
   function automatic int half_db_steps(input int db_x2);
      return db_x2;
   endfunction

endpackage

// File: rtl/atten_sclk_edge.sv
module atten_sclk_edge #(
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic clk,
   input  logic por,
   input  logic sclk_i,
   output logic shift_o
);

   generate
      if (EDGE_DETECT) begin : g_edge
         logic sclk_q;
         always_ff @(posedge clk) begin
            sclk_q <= sclk_i;
         end
         assign shift_o = sclk_i & ~sclk_q & ~por;
      end else begin : g_level
         assign shift_o = sclk_i & ~por;
      end
   endgenerate

endmodule

// File: rtl/atten_shreg.sv
module atten_shreg #(
   parameter int  WORD_W    = 6,
   parameter bit  MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              por,
   input  logic              shift_i,
   input  logic              din_i,
   output logic [WORD_W-1:0] sreg_o
);

   localparam int TOP = WORD_W - 1;

   logic [WORD_W-1:0] sreg_d;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sreg_d = {sreg_o[TOP-1:0], din_i};
      end else begin : g_lsb
         assign sreg_d = {din_i, sreg_o[TOP:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (por)          sreg_o <= '0;
      else if (shift_i) sreg_o <= sreg_d;
   end

   // R4
   sreg_hold_chk: assert property (@(posedge clk) disable iff (por)
      !shift_i |=> $stable(sreg_o));

   // R4
   sreg_clear_chk: assert property (@(posedge clk)
      por |=> (sreg_o == '0));

endmodule

// File: rtl/atten_preset.sv
module atten_preset #(
   parameter int WORD_W = 6,
   parameter int CODE_0 = 0,
   parameter int CODE_1 = 16,
   parameter int CODE_2 = 32,
   parameter int CODE_3 = 62
) (
   input  logic [1:0]        sel_i,
   output logic [WORD_W-1:0] code_o
);

   localparam logic [WORD_W-1:0] C0 = WORD_W'(CODE_0);
   localparam logic [WORD_W-1:0] C1 = WORD_W'(CODE_1);
   localparam logic [WORD_W-1:0] C2 = WORD_W'(CODE_2);
   localparam logic [WORD_W-1:0] C3 = WORD_W'(CODE_3);

   always_comb begin
      unique case (sel_i)
         2'd0:    code_o = C0;
         2'd1:    code_o = C1;
         2'd2:    code_o = C2;
         default: code_o = C3;
      endcase
   end

endmodule

// File: rtl/atten_out_latch.sv
module atten_out_latch
   import atten_pkg::*;
#(
   parameter int WORD_W = 6
) (
   input  logic              clk,
   input  logic              por,
   input  atten_src_e        src_i,
   input  logic              le_i,
   input  logic [WORD_W-1:0] sreg_i,
   input  logic [WORD_W-1:0] par_i,
   input  logic [WORD_W-1:0] preset_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] live_src;
   logic [WORD_W-1:0] boot_src;

   assign live_src = (src_i == SRC_SERIAL) ? sreg_i : par_i;
   assign boot_src = ((src_i == SRC_SERIAL) || le_i) ? par_i : preset_i;

   always_ff @(posedge clk) begin
      if (por)       word_o <= boot_src;
      else if (le_i) word_o <= live_src;
   end

   // R6
   hold_low_chk: assert property (@(posedge clk) disable iff (por)
      !le_i |=> $stable(word_o));

   // R5
   ser_follow_chk: assert property (@(posedge clk) disable iff (por)
      (le_i && src_i == SRC_SERIAL) |=> (word_o == $past(sreg_i)));

   // R7
   par_follow_chk: assert property (@(posedge clk) disable iff (por)
      (le_i && src_i == SRC_PARALLEL) |=> (word_o == $past(par_i)));

   // R1
   boot_serial_chk: assert property (@(posedge clk)
      (por && src_i == SRC_SERIAL) |=> (word_o == $past(par_i)));

   // R2
   boot_preset_chk: assert property (@(posedge clk)
      (por && src_i == SRC_PARALLEL && !le_i) |=> (word_o == $past(preset_i)));

   // R3
   boot_direct_chk: assert property (@(posedge clk)
      (por && src_i == SRC_PARALLEL && le_i) |=> (word_o == $past(par_i)));

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
   import atten_pkg::*;
#(
   parameter int WORD_W      = 6,
   parameter bit MSB_FIRST   = 1'b1,
   parameter bit EDGE_DETECT = 1'b1,
   parameter int PRESET_0    = 0,
   parameter int PRESET_1    = 16,
   parameter int PRESET_2    = 32,
   parameter int PRESET_3    = 62
) (
   input  logic              clk,
   input  logic              por,
   input  logic              mode_ser,
   input  logic              latch_en,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic [WORD_W-1:0] par_word,
   input  logic [1:0]        pup_sel,
   output logic [WORD_W-1:0] atten_word
);

   localparam int MAX_CODE = (1 << WORD_W) - 1;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("step_atten_ctrl: WORD_W must be at least 2");
      end
      if (PRESET_0 > MAX_CODE || PRESET_1 > MAX_CODE ||
          PRESET_2 > MAX_CODE || PRESET_3 > MAX_CODE) begin : g_bad_preset
         $error("step_atten_ctrl: a preset code exceeds the word range");
      end
   endgenerate

   logic              shift_pulse;
   logic [WORD_W-1:0] sreg;
   logic [WORD_W-1:0] preset_code;
   atten_src_e        src_sel;

   assign src_sel = mode_ser ? SRC_SERIAL : SRC_PARALLEL;

   atten_sclk_edge #(.EDGE_DETECT(EDGE_DETECT)) edge_i (
      .clk    (clk),
      .por    (por),
      .sclk_i (ser_clk),
      .shift_o(shift_pulse)
   );

   atten_shreg #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) shreg_i (
      .clk    (clk),
      .por    (por),
      .shift_i(shift_pulse),
      .din_i  (ser_dat),
      .sreg_o (sreg)
   );

   atten_preset #(
      .WORD_W(WORD_W), .CODE_0(PRESET_0), .CODE_1(PRESET_1),
      .CODE_2(PRESET_2), .CODE_3(PRESET_3)
   ) preset_i (
      .sel_i (pup_sel),
      .code_o(preset_code)
   );

   atten_out_latch #(.WORD_W(WORD_W)) latch_i (
      .clk     (clk),
      .por     (por),
      .src_i   (src_sel),
      .le_i    (latch_en),
      .sreg_i  (sreg),
      .par_i   (par_word),
      .preset_i(preset_code),
      .word_o  (atten_word)
   );

   // R9
   no_preset_rerun_chk: assert property (@(posedge clk) disable iff (por)
      ($past(mode_ser) != mode_ser && !latch_en) |=> $stable(atten_word));

endmodule

// File: tb/step_atten_ctrl_tb.sv
module step_atten_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       r_por = 1'b1, r_mode = 1'b1, r_le = 1'b0;
   logic       r_sclk = 1'b0, r_sdat = 1'b0;
   logic [5:0] r_par = 6'h2B;
   logic [1:0] r_pup = 2'd0;
   logic [5:0] dut_word;

   int    n_checks = 0;
   int    n_errors = 0;
   int    m_word = 0;
   int    m_sreg = 0;
   int    m_prev = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   step_atten_ctrl dut_i (
      .clk(clk), .por(r_por), .mode_ser(r_mode), .latch_en(r_le),
      .ser_clk(r_sclk), .ser_dat(r_sdat), .par_word(r_par),
      .pup_sel(r_pup), .atten_word(dut_word)
   );

   function automatic int preset_of(input int sel);
      case (sel)
         0: return 0;
         1: return 16;
         2: return 32;
         default: return 62;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: atten_word=%0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: model update at the edge, comparison at the falling edge.
   task automatic tick();
      @(posedge clk);
      if (r_por) begin
         m_word = (r_mode || r_le) ? int'(r_par) : preset_of(int'(r_pup));
         m_sreg = 0;
      end else begin
         if (r_le) m_word = r_mode ? m_sreg : int'(r_par);
         if (r_sclk && m_prev == 0) m_sreg = ((m_sreg << 1) | int'(r_sdat)) & 63;
      end
      m_prev = int'(r_sclk);
      @(negedge clk);
      chk(cur_req, int'(dut_word), m_word);
   endtask

   task automatic ser_load(input int val);
      for (int i = 5; i >= 0; i--) begin
         r_sdat = val[i];
         r_sclk = 1'b0; tick();
         r_sclk = 1'b1; tick();
      end
      r_sclk = 1'b0; tick();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      // R1: serial-mode power-on takes the parallel pins
      cur_req = "R1";
      tick(); tick();
      r_por = 1'b0; tick();
      chk("R1", int'(dut_word), 6'h2B);

      // R2: each preset code
      cur_req = "R2";
      r_mode = 1'b0; r_le = 1'b0; r_par = 6'h3F;
      for (int s = 0; s < 4; s++) begin
         r_pup = 2'(s); r_por = 1'b1; tick();
         r_por = 1'b0; tick();
         chk("R2", int'(dut_word), (s == 0) ? 0 : (s == 1) ? 16 : (s == 2) ? 32 : 62);
      end

      // R3: direct parallel at power-on ignores presets
      cur_req = "R3";
      r_le = 1'b1; r_pup = 2'd3; r_par = 6'h15; r_por = 1'b1; tick();
      r_por = 1'b0; r_le = 1'b0; tick();
      chk("R3", int'(dut_word), 6'h15);

      // R6 and R9: held parallel output, no preset rerun
      cur_req = "R6";
      r_par = 6'h0A; r_pup = 2'd1; tick(); tick();
      chk("R6", int'(dut_word), 6'h15);

      // R8: latch pulse captures
      cur_req = "R8";
      r_le = 1'b1; tick();
      r_le = 1'b0; r_par = 6'h33; tick(); tick();
      chk("R8", int'(dut_word), 6'h0A);

      // R7: direct parallel follows
      cur_req = "R7";
      r_le = 1'b1;
      for (int v = 0; v < 64; v += 9) begin
         r_par = 6'(v); tick();
      end
      tick();
      chk("R7", int'(dut_word), 63);

      // R4 and R6: serial shift with latch low leaves output alone
      cur_req = "R6";
      r_le = 1'b0; r_mode = 1'b1; r_par = 6'h01;
      ser_load(6'h2D);
      chk("R6", int'(dut_word), 63);
      cur_req = "R4";
      r_le = 1'b1; tick();
      chk("R4", int'(dut_word), 6'h2D);
      r_le = 1'b0; tick();

      // R5: transparent latch passes intermediate shift values
      cur_req = "R5";
      r_le = 1'b1;
      ser_load(6'h31);
      chk("R5", int'(dut_word), 6'h31);

      // R9: mode switch with latch open picks the parallel pins
      cur_req = "R9";
      r_par = 6'h07; r_mode = 1'b0; tick();
      chk("R9", int'(dut_word), 6'h07);
      r_le = 1'b0; r_mode = 1'b1; r_pup = 2'd2; tick(); tick();
      chk("R9", int'(dut_word), 6'h07);
      r_le = 1'b1; tick();
      chk("R9", int'(dut_word), 6'h31);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule